// File: doc/BRIEF.md
# Double-Indexed 2D Address Generator

This block produces the sequence of byte addresses needed to read a framebuffer out of memory as a two-dimensional walk. A configuration gives the buffer base, the visible width and height in pixels, an optional line stride wider than the visible width, optional horizontal and vertical pixel-skip factors, a quarter-turn rotation, a mirror flag and the pixel size. On a start pulse an internal helper turns these settings into a start address, an element count, a frame count, a signed element index and a signed frame index. A walker then emits one address per accepted handshake. It flags the last element of each frame and every address of the last frame.

The walker never multiplies. Each next address is the current address plus the element size minus one plus a sign-extended index. The element index is used inside a frame and the frame index when a frame wraps. Any rotation or mirror order therefore costs one adder in the address path. The block also reports the end address of the walk. In legacy mode with 32-bit pixels, that end address is offset by two bytes.

Top module: `a2d_addr_gen`

## Requirements
- R1: `dtype` selects the pixel size: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. Code 3 is invalid, and a start with it is ignored (`addr_valid` stays low and `done` stays low).
- R2: Pixel (x,y) lies at byte address base + (y*S*YS + x*XS)*size. S is `stride`, or `width` when `stride` is 0. XS and YS are `xscale` and `yscale`, each taken as 1 when programmed as 0.
- R3: A start is ignored when `stride` is nonzero and smaller than `width`, or when `width` or `height` is 0.
- R4: `rotation` 0 and 2 (0° and 180°) walk `width` elements per frame and `height` frames. `rotation` 1 and 3 (90° and 270°) walk `height` elements per frame and `width` frames. Element i of frame j, without mirror, visits: rot 0 (i,j); rot 1 (j,h-1-i); rot 2 (w-1-i,h-1-j); rot 3 (w-1-j,i).
- R5: With `mirror` set, element i of frame j visits: rot 0 (w-1-i,j); rot 1 (w-1-j,h-1-i); rot 2 (i,h-1-j); rot 3 (j,i).
- R6: Successive addresses come from signed steps. Negative element and frame steps, as in mirrored and rotated walks, produce the addresses of R4 and R5 exactly.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr`, `last_elem` and `last_frame` hold their values. An address is consumed only on a cycle with both high.
- R8: `last_elem` is high with the final address of each frame. `last_frame` is high with every address of the final frame.
- R9: The cycle after the final address is consumed, `done` is high for exactly one cycle and `addr_valid` is low.
- R10: A start while a walk is in progress is ignored, and the running sequence continues unchanged.
- R11: From the first address of a walk, `end_addr` holds the address of the final pixel visited. When `legacy_end` is set and `dtype` is 2, `end_addr` is that address plus 2.
- R12: After reset, `addr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk with the present configuration |
| base_addr | input | ADDR_W | Framebuffer base byte address |
| width | input | DIM_W | Visible width in pixels |
| height | input | DIM_W | Visible height in pixels |
| stride | input | DIM_W | Line stride in pixels, 0 means width |
| xscale | input | SCL_W | Horizontal pixel skip, 0 means 1 |
| yscale | input | SCL_W | Vertical line skip, 0 means 1 |
| rotation | input | 2 | Quarter turns: 0,1,2,3 |
| mirror | input | 1 | Horizontal mirror |
| dtype | input | 2 | Pixel size code |
| legacy_end | input | 1 | Apply the legacy end-address offset |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_valid | output | 1 | Address is valid |
| addr | output | ADDR_W | Byte address |
| last_elem | output | 1 | Last element of a frame |
| last_frame | output | 1 | Address belongs to the last frame |
| done | output | 1 | One-cycle pulse after the final address |
| end_addr | output | ADDR_W | End address of the walk |

## Verification
The bench places every pixel from its own coordinates for all four rotations with and without mirror. It also covers pixel-skip factors, a stride wider than the width and a single-pixel frame. A wrong sign extension or a wrong frame-wrap step shows up as a jump to the wrong line at the first frame boundary, and a swapped count shows up as a flag in the wrong place. The consumer stalls one cycle in three, so an address that advances without a handshake appears as a skipped pixel. Starts with an invalid size code, a narrow stride, a zero height, or during a running walk must leave the outputs untouched, while a careless load would restart the walk. A design that omits or misplaces the legacy offset is caught on the 32-bit legacy case.

// File: rtl/a2d_pkg.sv
package a2d_pkg;

  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  typedef struct packed {
    logic [31:0] x;
    logic [31:0] y;
  } xy_t;

  // Pixel size in bytes; 0 marks an illegal code.
  function automatic logic [2:0] elem_bytes(input logic [1:0] dt);
    case (dt)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] or_one(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

  // Coordinate of element i in frame j for a given orientation.
  function automatic xy_t walk_xy(input rot_e rot, input logic mir,
                                  input logic [31:0] w, input logic [31:0] h,
                                  input logic [31:0] i, input logic [31:0] j);
    xy_t p;
    case (rot)
      ROT_0:   begin p.x = mir ? (w - 32'd1 - i) : i;            p.y = j; end
      ROT_90:  begin p.x = mir ? (w - 32'd1 - j) : j;            p.y = h - 32'd1 - i; end
      ROT_180: begin p.x = mir ? i : (w - 32'd1 - i);            p.y = h - 32'd1 - j; end
      default: begin p.x = mir ? j : (w - 32'd1 - j);            p.y = i; end
    endcase
    return p;
  endfunction

  function automatic logic [31:0] pix_off(input xy_t p, input logic [31:0] st,
                                          input logic [31:0] xs, input logic [31:0] ys,
                                          input logic [2:0] es);
    return (p.y * st * ys + p.x * xs) * {29'd0, es};
  endfunction

endpackage

// File: rtl/a2d_index_calc.sv
module a2d_index_calc
  import a2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 11,
  parameter int SCL_W  = 4,
  parameter int EI_W   = 16,
  parameter int FI_W   = 32
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [DIM_W-1:0]  stride,
  input  logic [SCL_W-1:0]  xscale,
  input  logic [SCL_W-1:0]  yscale,
  input  logic [1:0]        rotation,
  input  logic              mirror,
  input  logic [1:0]        dtype,
  input  logic              legacy_end,
  output logic [ADDR_W-1:0] top_addr,
  output logic [ADDR_W-1:0] end_addr,
  output logic [EI_W-1:0]   elem_idx,
  output logic [FI_W-1:0]   frame_idx,
  output logic [DIM_W-1:0]  elem_cnt,
  output logic [DIM_W-1:0]  frame_cnt,
  output logic [2:0]        elem_size,
  output logic              cfg_ok
);

  rot_e        rot;
  logic [31:0] w32, h32, st32, xs32, ys32, en32, fn32, es32;
  xy_t         p_first, p_second, p_row_end, p_next_row, p_final;
  logic [31:0] o_first, o_second, o_row_end, o_next_row, o_final;

  assign rot       = rot_e'(rotation);
  assign elem_size = elem_bytes(dtype);
  assign es32      = {29'd0, elem_size};
  assign w32       = 32'(width);
  assign h32       = 32'(height);
  assign st32      = (stride == '0) ? w32 : 32'(stride);
  assign xs32      = or_one(32'(xscale));
  assign ys32      = or_one(32'(yscale));

  // Quarter turns swap the roles of the two counts.
  assign elem_cnt  = rotation[0] ? height : width;
  assign frame_cnt = rotation[0] ? width  : height;
  assign en32      = 32'(elem_cnt);
  assign fn32      = 32'(frame_cnt);

  assign cfg_ok = (elem_size != 3'd0) && (width != '0) && (height != '0) &&
                  ((stride == '0) || (stride >= width));

  assign p_first    = walk_xy(rot, mirror, w32, h32, 32'd0, 32'd0);
  assign p_second   = walk_xy(rot, mirror, w32, h32, 32'd1, 32'd0);
  assign p_row_end  = walk_xy(rot, mirror, w32, h32, en32 - 32'd1, 32'd0);
  assign p_next_row = walk_xy(rot, mirror, w32, h32, 32'd0, 32'd1);
  assign p_final    = walk_xy(rot, mirror, w32, h32, en32 - 32'd1, fn32 - 32'd1);

  assign o_first    = pix_off(p_first,    st32, xs32, ys32, elem_size);
  assign o_second   = pix_off(p_second,   st32, xs32, ys32, elem_size);
  assign o_row_end  = pix_off(p_row_end,  st32, xs32, ys32, elem_size);
  assign o_next_row = pix_off(p_next_row, st32, xs32, ys32, elem_size);
  assign o_final    = pix_off(p_final,    st32, xs32, ys32, elem_size);

  // Index = distance - size + 1, so 1 means the next contiguous element.
  assign elem_idx  = EI_W'(o_second - o_first - es32 + 32'd1);
  assign frame_idx = FI_W'(o_next_row - o_row_end - es32 + 32'd1);

  assign top_addr = base_addr + ADDR_W'(o_first);
  assign end_addr = base_addr + ADDR_W'(o_final) +
                    ((legacy_end && dtype == 2'd2) ? ADDR_W'(2) : ADDR_W'(0));

endmodule

// File: rtl/a2d_walker.sv
module a2d_walker #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 11,
  parameter int EI_W   = 16,
  parameter int FI_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] top_addr,
  input  logic [EI_W-1:0]   elem_idx,
  input  logic [FI_W-1:0]   frame_idx,
  input  logic [DIM_W-1:0]  elem_cnt,
  input  logic [DIM_W-1:0]  frame_cnt,
  input  logic [2:0]        elem_size,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic              last_elem,
  output logic              last_frame,
  output logic              done
);

  logic              busy;
  logic [ADDR_W-1:0] addr_q;
  logic [DIM_W-1:0]  ecnt, fcnt, en_q, fn_q;
  logic [EI_W-1:0]   ei_q;
  logic [FI_W-1:0]   fi_q;
  logic [2:0]        es_q;
  logic              done_q;

  // Named events for the assertions.
  logic              fire, row_end, final_frame, finish;
  logic [ADDR_W-1:0] bump, step_elem, step_frame;

  assign fire        = busy & ready;
  assign row_end     = (ecnt == en_q - DIM_W'(1));
  assign final_frame = (fcnt == fn_q - DIM_W'(1));
  assign finish      = fire & row_end & final_frame;

  assign bump       = addr_q + ADDR_W'(es_q) - ADDR_W'(1);
  assign step_elem  = bump + ADDR_W'($signed(ei_q));
  assign step_frame = bump + ADDR_W'($signed(fi_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr_q <= '0;
      ecnt   <= '0;
      fcnt   <= '0;
      en_q   <= '0;
      fn_q   <= '0;
      ei_q   <= '0;
      fi_q   <= '0;
      es_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy   <= 1'b1;
        addr_q <= top_addr;
        ecnt   <= '0;
        fcnt   <= '0;
        en_q   <= elem_cnt;
        fn_q   <= frame_cnt;
        ei_q   <= elem_idx;
        fi_q   <= frame_idx;
        es_q   <= elem_size;
      end else if (fire) begin
        if (row_end) begin
          ecnt <= '0;
          if (final_frame) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            fcnt   <= fcnt + DIM_W'(1);
            addr_q <= step_frame;
          end
        end else begin
          ecnt   <= ecnt + DIM_W'(1);
          addr_q <= step_elem;
        end
      end
    end
  end

  assign valid      = busy;
  assign addr       = addr_q;
  assign last_elem  = busy & row_end;
  assign last_frame = busy & final_frame;
  assign done       = done_q;

  // R7: a stalled address holds with its flags.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(last_elem) && $stable(last_frame)))
    else $error("p_hold_r7");

  // R9: the final handshake is followed by a done pulse with valid low.
  p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !valid))
    else $error("p_finish_r9");

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("p_pulse_r9");

  // R8: the element counter stays inside the frame.
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (ecnt < en_q) && (fcnt < fn_q))
    else $error("p_cnt_bound_r8");

endmodule

// File: rtl/a2d_addr_gen.sv
module a2d_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 11,
  parameter int SCL_W  = 4,
  parameter int EI_W   = 16,
  parameter int FI_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [DIM_W-1:0]  stride,
  input  logic [SCL_W-1:0]  xscale,
  input  logic [SCL_W-1:0]  yscale,
  input  logic [1:0]        rotation,
  input  logic              mirror,
  input  logic [1:0]        dtype,
  input  logic              legacy_end,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              last_elem,
  output logic              last_frame,
  output logic              done,
  output logic [ADDR_W-1:0] end_addr
);

  logic [ADDR_W-1:0] top_c, end_c, end_q;
  logic [EI_W-1:0]   ei_c;
  logic [FI_W-1:0]   fi_c;
  logic [DIM_W-1:0]  en_c, fn_c;
  logic [2:0]        es_c;
  logic              cfg_ok, load;

  a2d_index_calc #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .SCL_W(SCL_W), .EI_W(EI_W), .FI_W(FI_W)
  ) u_calc (
    .base_addr (base_addr),
    .width     (width),
    .height    (height),
    .stride    (stride),
    .xscale    (xscale),
    .yscale    (yscale),
    .rotation  (rotation),
    .mirror    (mirror),
    .dtype     (dtype),
    .legacy_end(legacy_end),
    .top_addr  (top_c),
    .end_addr  (end_c),
    .elem_idx  (ei_c),
    .frame_idx (fi_c),
    .elem_cnt  (en_c),
    .frame_cnt (fn_c),
    .elem_size (es_c),
    .cfg_ok    (cfg_ok)
  );

  // A start is taken only when idle and the settings are legal.
  assign load = start & cfg_ok & ~addr_valid;

  a2d_walker #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .EI_W(EI_W), .FI_W(FI_W)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .top_addr  (top_c),
    .elem_idx  (ei_c),
    .frame_idx (fi_c),
    .elem_cnt  (en_c),
    .frame_cnt (fn_c),
    .elem_size (es_c),
    .ready     (addr_ready),
    .valid     (addr_valid),
    .addr      (addr),
    .last_elem (last_elem),
    .last_frame(last_frame),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    end_q <= '0;
    else if (load) end_q <= end_c;
  end

  assign end_addr = end_q;

  // R3 and R1: an illegal configuration never starts a walk.
  p_bad_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cfg_ok && !addr_valid) |=> !addr_valid)
    else $error("p_bad_cfg_r3");

  // R11 and R10: the end address is frozen for the whole walk.
  p_end_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid)) |-> $stable(end_addr))
    else $error("p_end_stable_r11");

endmodule

// File: tb/a2d_addr_gen_bench.sv
`timescale 1ns/1ps
module a2d_addr_gen_bench;

  localparam int NV = 10;
  localparam int V_W  [NV] = '{4, 4, 3, 3, 5, 5, 3, 2, 4, 1};
  localparam int V_H  [NV] = '{3, 3, 4, 4, 2, 2, 3, 3, 2, 1};
  localparam int V_ST [NV] = '{0, 0, 6, 6, 8, 0, 5, 0, 0, 0};
  localparam int V_XS [NV] = '{0, 0, 0, 0, 2, 0, 1, 0, 0, 0};
  localparam int V_YS [NV] = '{0, 0, 0, 0, 1, 0, 2, 0, 0, 0};
  localparam int V_ROT[NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 0, 0};
  localparam int V_MIR[NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 0};
  localparam int V_DT [NV] = '{1, 1, 0, 2, 1, 0, 2, 1, 2, 0};
  localparam int V_LEG[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam int V_BASE[NV] = '{'h1000, 'h2000, 'h3000, 'h4000, 'h5000,
                                'h6000, 'h7000, 'h8000, 'h9000, 'hA000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [10:0] width = '0, height = '0, stride = '0;
  logic [3:0]  xscale = '0, yscale = '0;
  logic [1:0]  rotation = '0, dtype = '0;
  logic        mirror = 1'b0, legacy_end = 1'b0, addr_ready = 1'b0;
  logic        addr_valid, last_elem, last_frame, done;
  logic [31:0] addr, end_addr;

  int checks = 0, errors = 0, rc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  a2d_addr_gen u_a2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .width(width), .height(height), .stride(stride), .xscale(xscale),
    .yscale(yscale), .rotation(rotation), .mirror(mirror), .dtype(dtype),
    .legacy_end(legacy_end), .addr_ready(addr_ready), .addr_valid(addr_valid),
    .addr(addr), .last_elem(last_elem), .last_frame(last_frame), .done(done),
    .end_addr(end_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int n_elem(input int k);
    return (V_ROT[k] % 2 == 1) ? V_H[k] : V_W[k];
  endfunction

  function automatic int n_frame(input int k);
    return (V_ROT[k] % 2 == 1) ? V_W[k] : V_H[k];
  endfunction

  // Expected address from the pixel placement rules.
  function automatic logic [31:0] exp_addr(input int k, input int i, input int j);
    int w = V_W[k], h = V_H[k];
    int line = (V_ST[k] == 0) ? w : V_ST[k];
    int sx = (V_XS[k] == 0) ? 1 : V_XS[k];
    int sy = (V_YS[k] == 0) ? 1 : V_YS[k];
    int bytes = 1 << V_DT[k];
    int x, y;
    if (V_ROT[k] == 0)      begin y = j;         x = V_MIR[k] ? w - 1 - i : i; end
    else if (V_ROT[k] == 2) begin y = h - 1 - j; x = V_MIR[k] ? i : w - 1 - i; end
    else if (V_ROT[k] == 1) begin y = h - 1 - i; x = V_MIR[k] ? w - 1 - j : j; end
    else                    begin y = i;         x = V_MIR[k] ? j : w - 1 - j; end
    return 32'(V_BASE[k] + (y * line * sy + x * sx) * bytes);
  endfunction

  task automatic apply_cfg(input int k);
    base_addr  = 32'(V_BASE[k]);
    width      = 11'(V_W[k]);
    height     = 11'(V_H[k]);
    stride     = 11'(V_ST[k]);
    xscale     = 4'(V_XS[k]);
    yscale     = 4'(V_YS[k]);
    rotation   = 2'(V_ROT[k]);
    mirror     = 1'(V_MIR[k]);
    dtype      = 2'(V_DT[k]);
    legacy_end = 1'(V_LEG[k]);
  endtask

  task automatic run_vec(input int k, input bit disturb);
    logic [31:0] e, fin;
    apply_cfg(k);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    fin = exp_addr(k, n_elem(k) - 1, n_frame(k) - 1);
    if (V_LEG[k] != 0 && V_DT[k] == 2) fin = fin + 32'd2;
    chk(end_addr == fin, "R11", $sformatf("vec%0d end_addr", k), end_addr, fin);
    for (int j = 0; j < n_frame(k); j++) begin
      for (int i = 0; i < n_elem(k); i++) begin
        bit got = 1'b0;
        e = exp_addr(k, i, j);
        for (int t = 0; t < 8 && !got; t++) begin
          apply_cfg(k);
          start = 1'b0;
          // R2 R4 R5 R6: address order; R7 when t>0 (stalled element).
          chk(addr_valid == 1'b1, (t > 0) ? "R7" : "R4", $sformatf("vec%0d valid e%0d f%0d", k, i, j),
              32'(addr_valid), 32'd1);
          chk(addr == e, (t > 0) ? "R7" : (V_MIR[k] != 0 ? "R5" : "R2"),
              $sformatf("vec%0d addr e%0d f%0d", k, i, j), addr, e);
          chk(last_elem == (i == n_elem(k) - 1) && last_frame == (j == n_frame(k) - 1), "R8",
              $sformatf("vec%0d flags e%0d f%0d", k, i, j), {30'd0, last_elem, last_frame},
              {30'd0, 1'(i == n_elem(k) - 1), 1'(j == n_frame(k) - 1)});
          if (disturb && i == 1 && j == 0 && t == 0) begin
            // R10: start during a walk with a different base
            start = 1'b1;
            base_addr = base_addr + 32'h100;
          end
          addr_ready = ((rc % 3) != 1);
          rc++;
          @(negedge clk);
          if (addr_ready) got = 1'b1;
        end
        start = 1'b0;
      end
    end
    addr_ready = 1'b0;
    chk(done == 1'b1 && addr_valid == 1'b0, "R9", $sformatf("vec%0d done pulse", k),
        {30'd0, done, addr_valid}, 32'd2);
    @(negedge clk);
    chk(done == 1'b0, "R9", $sformatf("vec%0d done width", k), 32'(done), 32'd0);
  endtask

  task automatic expect_ignored(input string req, input string what);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(addr_valid == 1'b0, req, {what, " valid"}, 32'(addr_valid), 32'd0);
    @(negedge clk);
    chk(addr_valid == 1'b0 && done == 1'b0, req, {what, " later"},
        {30'd0, addr_valid, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(addr_valid == 1'b0 && done == 1'b0, "R12", "in reset", {30'd0, addr_valid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_valid == 1'b0 && done == 1'b0, "R12", "after reset", {30'd0, addr_valid, done}, 32'd0);

    for (int k = 0; k < NV; k++) run_vec(k, k == 0);

    // R1: illegal size code
    apply_cfg(0); dtype = 2'd3;
    expect_ignored("R1", "dtype3");
    // R3: stride narrower than width
    apply_cfg(2); stride = 11'd2;
    expect_ignored("R3", "narrow stride");
    // R3: zero height
    apply_cfg(0); height = 11'd0;
    expect_ignored("R3", "zero height");

    // R10 again on a mirrored walk, then a walk after the rejected starts
    run_vec(1, 1'b1);
    run_vec(6, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule